// File: doc/BRIEF.md
# Bfloat16 Adder-Subtractor

This block takes two 16-bit brain-float operands and returns their sum or their difference. The operand layout is fixed by the format: bit 15 holds the sign, bits 14..7 hold an 8-bit exponent biased by 127, and bits 6..0 hold the fraction. A subtract select inverts the sign of the second operand before the shared addition path runs, so one datapath serves both operations.

Special operands are resolved before any arithmetic. NaNs propagate, infinities follow the usual same-sign and opposite-sign rules, and a zero on either side returns the other operand unchanged. Finite operands are aligned on the larger exponent. When the exponents differ by more than eight, the larger operand is returned as it is. Otherwise the significands are added or subtracted and the result is normalized in a single step. The fraction is truncated, with no guard, round or sticky bits. An exact cancellation, or an exponent that runs out during left normalization, gives +0.

A caller raises the valid input for one cycle together with the operands and the select. The registered result and the output valid appear on the next clock edge. The result register keeps its value while no new operation is presented.

Top module: `bf16_addsub_unit`

## Requirements
- R1: With the subtract select at 1, the result equals the addition result for the second operand with bit 15 inverted. With the select at 0, the operands are added as given.
- R2: If the first operand has exponent 0xFF and a nonzero fraction, it is returned. Otherwise, if the second (sign-adjusted) operand alone has exponent 0xFF, that operand is returned, whatever its fraction.
- R3: If both operands are infinite, the result is the sign-adjusted second operand when the signs match, and the canonical NaN 0x7FC0 when they differ. An infinite first operand with a finite second operand is returned.
- R4: A zero first operand (exponent and fraction both 0, either sign) returns the sign-adjusted second operand. Otherwise a zero second operand returns the first operand.
- R5: A hidden bit of weight 0x80 is prefixed only when the exponent is nonzero. The significand with the smaller exponent is shifted right by the exponent difference. A difference above 8 returns the larger-exponent operand unchanged.
- R6: With equal signs, a sum that reaches bit 8 is shifted right by one and the exponent is incremented.
- R7: If that increment brings the exponent to 0xFF, the result is an infinity carrying the common sign (sign in bit 15 joined with 0x7F80). Finite operands never produce a NaN.
- R8: With different signs, the smaller significand is subtracted from the larger, and the result takes the sign of the operand whose significand was larger (the first operand wins a tie). A zero difference gives 0x0000.
- R9: A nonzero difference is shifted left until bit 7 is set, and the exponent is reduced by the shift count. If the exponent would reach 0 or less during this shift, the result is 0x0000.
- R10: The packed fraction is the low 7 bits of the normalized significand. Bits shifted out are dropped, so rounding is toward zero.
- R11: When valid is high at a clock edge, the result for that operation and a high output valid appear after that edge. When valid is low, the output valid falls and the result keeps its value.
- R12: While reset is held, the output valid is 0 and the result is 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request for the current operands |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| sub_sel | input | 1 | 1 selects a minus b, 0 selects a plus b |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 16 | Registered sum or difference |

## Verification
The bench sweeps every pairing of a set of operands in both modes and compares each result with a bench-side arithmetic model. The operand set covers exponents at zero, one, the gap-of-eight boundary, the bias and the top two codes, each with several fractions and both signs. Directed vectors aim at the corner cases:
- Opposite infinities: a design that mishandled them would return an infinity instead of 0x7FC0.
- Exponent gaps of exactly 7, 8 and 9: an off-by-one bypass would drop or keep a bit it should not.
- Carry overflow at exponent 254: a design that got it wrong would wrap to a small exponent.
- Cancellation down to a single bit near the exponent floor: a design that got it wrong would produce a denormal-looking word or -0 instead of +0.
- A sum whose dropped bit would round up: a rounding design would differ from a truncating one in the last fraction bit.

// File: rtl/bf16_addsub_pkg.sv
`timescale 1ns/1ps
package bf16_addsub_pkg;
  localparam int BF_EXP_W  = 8;
  localparam int BF_FRAC_W = 7;

  typedef enum logic [1:0] {
    PATH_SPECIAL = 2'd0,
    PATH_GAP     = 2'd1,
    PATH_ARITH   = 2'd2
  } addsub_path_e;
endpackage

// File: rtl/bf16_special_case.sv
`timescale 1ns/1ps
module bf16_special_case #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 7
) (
  input  logic [EXP_W+FRAC_W:0] a_i,
  input  logic [EXP_W+FRAC_W:0] b_i,
  output logic                  hit_o,
  output logic [EXP_W+FRAC_W:0] word_o
);
  localparam int W = 1 + EXP_W + FRAC_W;
  localparam logic [EXP_W-1:0] EXP_ONES = {EXP_W{1'b1}};
  localparam logic [W-1:0] QNAN = {1'b0, EXP_ONES, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [EXP_W-1:0]  ea, eb;
  logic [FRAC_W-1:0] fa, fb;
  logic a_top, b_top, a_zero, b_zero, same_sign;

  assign ea = a_i[W-2 -: EXP_W];
  assign eb = b_i[W-2 -: EXP_W];
  assign fa = a_i[FRAC_W-1:0];
  assign fb = b_i[FRAC_W-1:0];
  assign a_top  = (ea == EXP_ONES);
  assign b_top  = (eb == EXP_ONES);
  assign a_zero = (ea == '0) && (fa == '0);
  assign b_zero = (eb == '0) && (fb == '0);
  assign same_sign = (a_i[W-1] == b_i[W-1]);

  always_comb begin
    hit_o  = 1'b1;
    word_o = a_i;
    if (a_top) begin
      if (fa != '0)                 word_o = a_i;
      else if (b_top)               word_o = ((fb != '0) || same_sign) ? b_i : QNAN;
      else                          word_o = a_i;
    end else if (b_top) begin
      word_o = b_i;
    end else if (a_zero) begin
      word_o = b_i;
    end else if (b_zero) begin
      word_o = a_i;
    end else begin
      hit_o  = 1'b0;
    end
  end
endmodule

// File: rtl/bf16_align.sv
`timescale 1ns/1ps
module bf16_align #(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 7,
  parameter int GAP_LIM = FRAC_W + 1
) (
  input  logic [EXP_W+FRAC_W:0] a_i,
  input  logic [EXP_W+FRAC_W:0] b_i,
  output logic                  gap_o,
  output logic [EXP_W+FRAC_W:0] gap_word_o,
  output logic [FRAC_W:0]       sig_a_o,
  output logic [FRAC_W:0]       sig_b_o,
  output logic [EXP_W-1:0]      exp_o
);
  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int SIG_W = FRAC_W + 1;
  localparam logic [EXP_W-1:0] GAP_E = EXP_W'(GAP_LIM);

  logic [EXP_W-1:0] ea, eb, mag;
  logic [SIG_W-1:0] full_a, full_b;
  logic a_ge;

  assign ea = a_i[W-2 -: EXP_W];
  assign eb = b_i[W-2 -: EXP_W];
  // hidden bit only for a nonzero exponent
  assign full_a = {(ea != '0), a_i[FRAC_W-1:0]};
  assign full_b = {(eb != '0), b_i[FRAC_W-1:0]};

  assign a_ge = (ea >= eb);
  assign mag  = a_ge ? (ea - eb) : (eb - ea);

  assign gap_o      = (mag > GAP_E);
  assign gap_word_o = a_ge ? a_i : b_i;
  assign exp_o      = a_ge ? ea : eb;
  assign sig_a_o    = a_ge ? full_a : (full_a >> mag);
  assign sig_b_o    = a_ge ? (full_b >> mag) : full_b;
endmodule

// File: rtl/bf16_norm_pack.sv
`timescale 1ns/1ps
module bf16_norm_pack #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 7
) (
  input  logic                  sign_a_i,
  input  logic                  sign_b_i,
  input  logic [FRAC_W:0]       sig_a_i,
  input  logic [FRAC_W:0]       sig_b_i,
  input  logic [EXP_W-1:0]      exp_i,
  output logic [EXP_W+FRAC_W:0] word_o,
  output logic                  flush_o
);
  localparam int SIG_W = FRAC_W + 1;
  localparam int LZ_W  = $clog2(SIG_W + 1);
  localparam logic [EXP_W:0] EXP_LIM = {1'b0, {EXP_W{1'b1}}};

  logic [SIG_W:0]    sum;
  logic [SIG_W-1:0]  dif, above, ahead;
  logic [LZ_W-1:0]   lz;
  logic [EXP_W-1:0]  lz_e, exp_dn;
  logic [EXP_W:0]    exp_up;
  logic [FRAC_W-1:0] frac_left;
  logic a_big, res_sign;

  assign sum      = {1'b0, sig_a_i} + {1'b0, sig_b_i};
  assign a_big    = (sig_a_i >= sig_b_i);
  assign dif      = a_big ? (sig_a_i - sig_b_i) : (sig_b_i - sig_a_i);
  assign res_sign = a_big ? sign_a_i : sign_b_i;

  // priority encoder: "above[i]" is set when any bit higher than i is one
  assign above[SIG_W-1] = 1'b0;
  generate
    for (genvar i = 0; i < SIG_W - 1; i++) begin : g_chain
      assign above[i] = above[i+1] | dif[i+1];
    end
  endgenerate
  assign ahead = ~above & ~dif;
  assign lz    = LZ_W'($countones(ahead));
  assign lz_e  = {{(EXP_W-LZ_W){1'b0}}, lz};

  assign exp_up    = {1'b0, exp_i} + 1'b1;
  assign exp_dn    = exp_i - lz_e;
  assign frac_left = dif[FRAC_W-1:0] << lz;

  always_comb begin
    flush_o = 1'b0;
    word_o  = '0;
    if (sign_a_i == sign_b_i) begin
      if (sum[SIG_W]) begin
        if (exp_up >= EXP_LIM)
          word_o = {sign_a_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else
          word_o = {sign_a_i, exp_up[EXP_W-1:0], sum[FRAC_W:1]};
      end else begin
        word_o = {sign_a_i, exp_i, sum[FRAC_W-1:0]};
      end
    end else begin
      if (dif == '0) begin
        flush_o = 1'b1;
      end else if ((lz != '0) && (exp_i <= lz_e)) begin
        flush_o = 1'b1;
      end else begin
        word_o = {res_sign, exp_dn, frac_left};
      end
    end
  end
endmodule

// File: rtl/bf16_addsub_unit.sv
`timescale 1ns/1ps
module bf16_addsub_unit
  import bf16_addsub_pkg::*;
#(
  parameter int EXP_W  = BF_EXP_W,
  parameter int FRAC_W = BF_FRAC_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [EXP_W+FRAC_W:0] op_a,
  input  logic [EXP_W+FRAC_W:0] op_b,
  input  logic                  sub_sel,
  output logic                  out_valid,
  output logic [EXP_W+FRAC_W:0] result
);
  localparam int W = 1 + EXP_W + FRAC_W;
  localparam logic [EXP_W-1:0] EXP_ONES = {EXP_W{1'b1}};
  localparam logic [W-1:0] QNAN = {1'b0, EXP_ONES, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [W-1:0]      b_eff, spec_word, gap_word, arith_word, next_word;
  logic              spec_hit, gap_hit, flush;
  logic [FRAC_W:0]   sig_a, sig_b;
  logic [EXP_W-1:0]  exp_r;
  addsub_path_e      path;

  assign b_eff = {op_b[W-1] ^ sub_sel, op_b[W-2:0]};

  bf16_special_case #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_special (
    .a_i(op_a), .b_i(b_eff), .hit_o(spec_hit), .word_o(spec_word)
  );

  bf16_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .GAP_LIM(FRAC_W + 1)) u_align (
    .a_i(op_a), .b_i(b_eff), .gap_o(gap_hit), .gap_word_o(gap_word),
    .sig_a_o(sig_a), .sig_b_o(sig_b), .exp_o(exp_r)
  );

  bf16_norm_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
    .sign_a_i(op_a[W-1]), .sign_b_i(b_eff[W-1]), .sig_a_i(sig_a), .sig_b_i(sig_b),
    .exp_i(exp_r), .word_o(arith_word), .flush_o(flush)
  );

  always_comb begin
    if (spec_hit)     path = PATH_SPECIAL;
    else if (gap_hit) path = PATH_GAP;
    else              path = PATH_ARITH;
    case (path)
      PATH_SPECIAL: next_word = spec_word;
      PATH_GAP:     next_word = gap_word;
      default:      next_word = arith_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_word;
    end
  end

  // R11: valid propagates in one cycle, result holds while idle
  a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result)));

  // R12: reset clears the output register
  a_r12_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0));

  // R3: opposite infinities give the canonical NaN
  a_r3_inf_clash: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_a[W-2:0] == {EXP_ONES, {FRAC_W{1'b0}}} &&
     b_eff[W-2:0] == {EXP_ONES, {FRAC_W{1'b0}}} && (op_a[W-1] != b_eff[W-1]))
    |=> (result == QNAN));

  // R8 / R9: a flushed difference is always +0
  a_r9_flush_positive: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !spec_hit && !gap_hit && flush) |=> (result == '0));

  // R7: finite operands never yield a NaN
  a_r7_no_nan_from_finite: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !spec_hit) |=>
    !((result[W-2 -: EXP_W] == EXP_ONES) && (result[FRAC_W-1:0] != '0)));
endmodule

// File: tb/bf16_addsub_unit_test.sv
`timescale 1ns/1ps
module bf16_addsub_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic        sub_sel = 1'b0;
  logic        out_valid;
  logic [15:0] result;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [15:0] ops [128];

  always #2.5 clk = ~clk;

  bf16_addsub_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .sub_sel(sub_sel), .out_valid(out_valid), .result(result)
  );

  function automatic logic [15:0] model(input logic [15:0] a, input logic [15:0] b_in, input bit sub);
    logic [15:0] b;
    int sa, sb, ea, eb, ma, mb, ed, re, rs, rm;
    b  = b_in ^ (sub ? 16'h8000 : 16'h0000);
    sa = a[15]; sb = b[15];
    ea = a[14:7]; eb = b[14:7];
    ma = a[6:0]; mb = b[6:0];
    if (ea == 255) begin
      if (ma != 0) return a;
      if (eb == 255) return ((mb != 0) || (sa == sb)) ? b : 16'h7FC0;
      return a;
    end
    if (eb == 255) return b;
    if (ea == 0 && ma == 0) return b;
    if (eb == 0 && mb == 0) return a;
    if (ea != 0) ma = ma + 128;
    if (eb != 0) mb = mb + 128;
    ed = ea - eb;
    if (ed > 0) begin
      re = ea; if (ed > 8) return a; mb = mb >> ed;
    end else if (ed < 0) begin
      re = eb; if (ed < -8) return b; ma = ma >> (-ed);
    end else re = ea;
    if (sa == sb) begin
      rs = sa; rm = ma + mb;
      if (rm >= 256) begin
        rm = rm >> 1; re = re + 1;
        if (re >= 255) return {rs[0], 15'h7F80};
      end
    end else begin
      if (ma >= mb) begin rs = sa; rm = ma - mb; end
      else begin rs = sb; rm = mb - ma; end
      if (rm == 0) return 16'h0000;
      while (rm < 128) begin
        rm = rm << 1; re = re - 1;
        if (re <= 0) return 16'h0000;
      end
    end
    return {rs[0], re[7:0], rm[6:0]};
  endfunction

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run(input logic [15:0] a, input logic [15:0] b, input bit s,
                     input logic [15:0] exp, input string tag);
    @(negedge clk);
    op_a = a; op_b = b; sub_sel = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {15'h0, out_valid}, 16'h0001);
    check(tag, result, exp);
  endtask

  initial begin
    #(150000 * 5);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    int exps [16] = '{0, 1, 2, 7, 8, 9, 10, 126, 127, 128, 135, 136, 137, 253, 254, 255};
    int fracs [4] = '{0, 1, 64, 127};
    logic [15:0] held;
    for (int s = 0; s < 2; s++)
      for (int e = 0; e < 16; e++)
        for (int f = 0; f < 4; f++)
          ops[s*64 + e*4 + f] = {s[0], exps[e][7:0], fracs[f][6:0]};

    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 out_valid in reset", {15'h0, out_valid}, 16'h0000);
    check("R12 result in reset", result, 16'h0000);
    rst = 1'b0;

    // directed corner cases
    run(16'h3F80, 16'h3F80, 1'b0, 16'h4000, "R6 1+1 carry");
    run(16'h4040, 16'h4080, 1'b0, 16'h40E0, "R5 3+4 align");
    run(16'h3F80, 16'h3F80, 1'b1, 16'h0000, "R1 R8 1-1 cancel");
    run(16'hBF80, 16'h3F80, 1'b0, 16'h0000, "R8 -1+1 gives +0");
    run(16'h3F80, 16'h4000, 1'b1, 16'hBF80, "R8 sign of larger");
    run(16'h4B80, 16'h3F80, 1'b0, 16'h4B80, "R5 gap 24 bypass");
    run(16'h3F80, 16'h4300, 1'b0, 16'h4301, "R5 gap 7 keeps bit");
    run(16'h4380, 16'h3FFF, 1'b0, 16'h4380, "R5 gap 8 drops all");
    run(16'h3F80, 16'h4400, 1'b1, 16'hC400, "R5 gap 9 returns b flipped");
    run(16'h7F80, 16'hFF80, 1'b0, 16'h7FC0, "R3 inf minus inf");
    run(16'h7F80, 16'h7F80, 1'b1, 16'h7FC0, "R3 R1 inf sub inf");
    run(16'hFF80, 16'hFF80, 1'b0, 16'hFF80, "R3 same-sign infs");
    run(16'h7F80, 16'h4000, 1'b0, 16'h7F80, "R3 inf plus finite");
    run(16'h7FC1, 16'hFF80, 1'b0, 16'h7FC1, "R2 NaN a");
    run(16'h7F80, 16'hFFC5, 1'b0, 16'hFFC5, "R2 inf a NaN b");
    run(16'h3F80, 16'h7FC3, 1'b1, 16'hFFC3, "R2 NaN b sign flipped");
    run(16'h7F7F, 16'h7F7F, 1'b0, 16'h7F80, "R7 overflow positive");
    run(16'hFF7F, 16'h7F7F, 1'b1, 16'hFF80, "R7 overflow negative");
    run(16'h0100, 16'h00FF, 1'b1, 16'h0000, "R9 underflow flush");
    run(16'h3F81, 16'h3F80, 1'b1, 16'h3C00, "R9 shift by seven");
    run(16'h8000, 16'h3F80, 1'b0, 16'h3F80, "R4 -0 plus b");
    run(16'h4000, 16'h8000, 1'b1, 16'h4000, "R4 b zero");
    run(16'h0000, 16'h3F80, 1'b1, 16'hBF80, "R4 R1 zero minus b");
    run(16'h3F83, 16'h3F80, 1'b0, 16'h4001, "R10 truncation");

    // R11: idle cycle keeps the result and drops valid
    held = result;
    @(negedge clk);
    check("R11 out_valid idle", {15'h0, out_valid}, 16'h0000);
    check("R11 result held", result, held);

    // sweep over operand pairs in both modes
    for (int i = 0; i < 128; i++)
      for (int j = 0; j < 128; j++)
        for (int s = 0; s < 2; s++)
          run(ops[i], ops[j], s[0], model(ops[i], ops[j], s[0]),
              s == 0 ? "R10 sweep add" : "R1 sweep sub");

    // R12: reset again after activity
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R12 result after reset", result, 16'h0000);
    report();
  end
endmodule